// File: doc/BRIEF.md
# Handshake Gate for Memory-to-Memory DMA

This block sits between a memory-to-memory DMA engine and the path that carries the engine's data requests. With handshaking off, a channel's requests go straight through and the engine moves data as fast as the system allows. With handshaking on, the channel holds back the engine's requests until external hardware, such as an external FIFO, signals on a dedicated request pin. The gate then lets through either one transfer or a programmed block of transfers for each rising edge on that pin.

There are `NCH` independent channels, one for each memory DMA unit. Each channel samples its asynchronous request pin through a two-flop synchroniser and detects rising edges. Edges that arrive while a grant is still being served are held in a saturating pending counter, so none are lost until the counter is full. A sticky flag records any edge that arrived when the counter was full. The engine is modelled as a request line into the gate and an acknowledge line that marks each completed transfer.

Top module: `hs_dma_gate`

## Requirements
- R1: After reset, every channel's `pendCount` is 0 and its `overflow` is 0. With handshaking enabled and no request edge seen, `gatedReq` stays low even while `dmaReq` is high.
- R2: While `hsEnable[c]` is 0, `gatedReq[c]` equals `dmaReq[c]` in the same cycle.
- R3: Request edges that occur while `hsEnable[c]` is 0 are ignored: no transfer is later granted for them. Any cycle with `hsEnable[c]` at 0 clears that channel's pending count and overflow flag.
- R4: `extReq` is synchronised by two flops and only its rising edges count. A request held high for many cycles grants exactly as much as one short pulse does.
- R5: When `blockMode[c]` is 0, each rising edge grants exactly one acknowledged transfer. `gatedReq[c]` is high for one acknowledged cycle per edge.
- R6: When `blockMode[c]` is 1, each rising edge grants a block of `blockLen[c*LENW +: LENW]` acknowledged transfers. The window stays open until that many acknowledges have been counted.
- R7: In block mode, a block length of 0 is treated as a block of 1.
- R8: `pendCount[c*CNTW +: CNTW]` reports the edges not yet turned into a grant. If no grant is open, the first edge opens one at once. So after n edges with no engine requests, the count reads n-1.
- R9: The pending count saturates at 2^CNTW-1. An edge that arrives while it is saturated sets `overflow[c]`, which stays set until handshaking is disabled on that channel.
- R10: `gatedReq[c]` is never high while `dmaReq[c]` is low.
- R11: Channels are independent: edges, enables and requests on one channel do not change another channel's count, flag or grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| hsEnable | input | NCH | Handshake mode enable per channel |
| blockMode | input | NCH | 1: block per edge, 0: one transfer per edge |
| blockLen | input | NCH*LENW | Block length per channel |
| extReq | input | NCH | Asynchronous external request pins |
| dmaReq | input | NCH | Data request from the DMA engine |
| dmaAck | input | NCH | Transfer acknowledge from the DMA engine |
| gatedReq | output | NCH | Request passed on to the data path |
| pendCount | output | NCH*CNTW | Pending edge count per channel |
| overflow | output | NCH | Sticky pending-overflow flag per channel |

## Verification
The hardest state to reach is a saturated pending counter with the overflow flag set, because a ready engine drains grants as fast as edges arrive. The stimulus holds the engine's request low, which stops the open window from closing. It then sends more edges than the counter can hold, checks the saturated count and the flag, and checks that the other channel is unaffected. A scoreboard records the expected burst lengths and compares them against the runs of `gatedReq`. This finds lost, merged or extra grants in single mode, block mode and the zero-length case.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
  typedef struct packed {
    logic clearAll;
    logic incPend;
    logic loadWin;
    logic ackWin;
  } gateStrobe_t;
endpackage

// File: rtl/hsg_edge_detect.sv
module hsg_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rise
);
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[SYNC_STAGES-1:0], asyncIn};
  end

  // chain[SYNC_STAGES-1] is the synchronised level, the top bit its previous value
  assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/hsg_ctrl.sv
module hsg_ctrl
  import hsg_pkg::*;
(
  input  logic        enable,
  input  logic        rise,
  input  logic        dmaReq,
  input  logic        dmaAck,
  input  logic        winOpen,
  input  logic        pendAny,
  output gateStrobe_t strobe,
  output logic        gatedReq
);
  always_comb begin
    strobe.clearAll = ~enable;
    strobe.incPend  = enable & rise;
    strobe.loadWin  = enable & ~winOpen & pendAny;
    strobe.ackWin   = enable & winOpen & dmaReq & dmaAck;
    gatedReq        = enable ? (dmaReq & winOpen) : dmaReq;
  end
endmodule

// File: rtl/hsg_dpath.sv
module hsg_dpath
  import hsg_pkg::*;
#(
  parameter int CNTW = 3,
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  gateStrobe_t     strobe,
  input  logic            blockMode,
  input  logic [LENW-1:0] blockLen,
  output logic [CNTW-1:0] pendCount,
  output logic            overflow,
  output logic            winOpen,
  output logic            pendAny
);
  localparam logic [CNTW-1:0] PEND_MAX = '1;

  logic [CNTW-1:0] pend;
  logic [LENW-1:0] win;
  logic [LENW-1:0] loadVal;
  logic            pendFull;
  logic            grow;
  logic            shrink;

  assign pendFull = (pend == PEND_MAX);
  assign grow     = strobe.incPend & ~strobe.loadWin;
  assign shrink   = strobe.loadWin & ~strobe.incPend;

  always_comb begin
    if (blockMode && (blockLen != '0)) loadVal = blockLen;
    else                               loadVal = LENW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= '0;
      win      <= '0;
      overflow <= 1'b0;
    end else if (strobe.clearAll) begin
      pend     <= '0;
      win      <= '0;
      overflow <= 1'b0;
    end else begin
      if (grow && !pendFull) pend <= pend + 1'b1;
      else if (shrink)       pend <= pend - 1'b1;
      if (grow && pendFull)  overflow <= 1'b1;
      if (strobe.loadWin)     win <= loadVal;
      else if (strobe.ackWin) win <= win - 1'b1;
    end
  end

  assign pendCount = pend;
  assign pendAny   = (pend != '0);
  assign winOpen   = (win != '0);
endmodule

// File: rtl/hs_dma_gate.sv
module hs_dma_gate
  import hsg_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int CNTW        = 3,
  parameter int LENW        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NCH-1:0]       hsEnable,
  input  logic [NCH-1:0]       blockMode,
  input  logic [NCH*LENW-1:0]  blockLen,
  input  logic [NCH-1:0]       extReq,
  input  logic [NCH-1:0]       dmaReq,
  input  logic [NCH-1:0]       dmaAck,
  output logic [NCH-1:0]       gatedReq,
  output logic [NCH*CNTW-1:0]  pendCount,
  output logic [NCH-1:0]       overflow
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic        rise;
    logic        winOpen;
    logic        pendAny;
    gateStrobe_t strobe;

    hsg_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rstN(rstN), .asyncIn(extReq[c]), .rise(rise)
    );

    hsg_ctrl u_ctrl (
      .enable(hsEnable[c]), .rise(rise), .dmaReq(dmaReq[c]), .dmaAck(dmaAck[c]),
      .winOpen(winOpen), .pendAny(pendAny), .strobe(strobe), .gatedReq(gatedReq[c])
    );

    hsg_dpath #(.CNTW(CNTW), .LENW(LENW)) u_dpath (
      .clk(clk), .rstN(rstN), .strobe(strobe), .blockMode(blockMode[c]),
      .blockLen(blockLen[c*LENW +: LENW]), .pendCount(pendCount[c*CNTW +: CNTW]),
      .overflow(overflow[c]), .winOpen(winOpen), .pendAny(pendAny)
    );
  end
endmodule

// File: rtl/hsg_checker.sv
module hsg_checker #(
  parameter int NCH  = 2,
  parameter int CNTW = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [NCH-1:0]      hsEnable,
  input logic [NCH-1:0]      dmaReq,
  input logic [NCH-1:0]      gatedReq,
  input logic [NCH*CNTW-1:0] pendCount,
  input logic [NCH-1:0]      overflow
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_passthru_r2: assert property (@(posedge clk) disable iff (!rstN)
      !hsEnable[c] |-> (gatedReq[c] == dmaReq[c]));

    p_clear_off_r3: assert property (@(posedge clk) disable iff (!rstN)
      !hsEnable[c] |=> (pendCount[c*CNTW +: CNTW] == '0 && !overflow[c]));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
      (hsEnable[c] && overflow[c]) |=> overflow[c]);

    p_ovf_full_r9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(overflow[c]) |-> (pendCount[c*CNTW +: CNTW] == {CNTW{1'b1}}));

    p_no_req_no_grant_r10: assert property (@(posedge clk) disable iff (!rstN)
      gatedReq[c] |-> dmaReq[c]);
  end
endmodule

bind hs_dma_gate hsg_checker #(.NCH(NCH), .CNTW(CNTW)) u_chk (
  .clk(clk), .rstN(rstN), .hsEnable(hsEnable), .dmaReq(dmaReq),
  .gatedReq(gatedReq), .pendCount(pendCount), .overflow(overflow)
);

// File: tb/hs_dma_gate_bench.sv
module hs_dma_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 2;
  localparam int CNTW = 3;
  localparam int LENW = 8;
  localparam int WATCHDOG_CYCLES = 150000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [NCH-1:0]      hsEnable = '0;
  logic [NCH-1:0]      blockMode = '0;
  logic [NCH*LENW-1:0] blockLen = '0;
  logic [NCH-1:0]      extReq = '0;
  logic [NCH-1:0]      dmaReq = '0;
  logic [NCH-1:0]      dmaAck;
  logic [NCH-1:0]      gatedReq;
  logic [NCH*CNTW-1:0] pendCount;
  logic [NCH-1:0]      overflow;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit monActive = 1'b0;
  int runLen = 0;
  int expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // engine model: acknowledges every request the gate lets through
  assign dmaAck = gatedReq;

  hs_dma_gate #(.NCH(NCH), .CNTW(CNTW), .LENW(LENW)) u_hs_dma_gate (
    .clk(clk), .rstN(rstN), .hsEnable(hsEnable), .blockMode(blockMode),
    .blockLen(blockLen), .extReq(extReq), .dmaReq(dmaReq), .dmaAck(dmaAck),
    .gatedReq(gatedReq), .pendCount(pendCount), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expectBurst(input int len, input string tag);
    expQ.push_back(len);
    tagQ.push_back(tag);
  endtask

  task automatic pulse(input int ch, input int highCycles);
    @(posedge clk); #1 extReq[ch] = 1'b1;
    repeat (highCycles) @(posedge clk);
    #1 extReq[ch] = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor on channel 0: each run of gatedReq is one grant
  always @(negedge clk) begin
    if (monActive) begin
      if (gatedReq[0]) runLen++;
      else if (runLen > 0) begin
        if (expQ.size() == 0) check(1'b0, "R5/R6 unexpected burst", runLen, 0);
        else begin
          int e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(runLen == e, t, runLen, e);
        end
        runLen = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    hsEnable = 2'b11;
    dmaReq   = 2'b11;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pendCount == '0, "R1 pendCount after reset", int'(pendCount), 0);
    check(overflow == '0, "R1 overflow after reset", int'(overflow), 0);
    check(gatedReq == '0, "R1 no grant without edge", int'(gatedReq), 0);

    // R2 passthrough while disabled
    #1 hsEnable = 2'b00; dmaReq = 2'b01;
    @(negedge clk);
    check(gatedReq == 2'b01, "R2 passthrough follows dmaReq", int'(gatedReq), 1);
    #1 dmaReq = 2'b10;
    @(negedge clk);
    check(gatedReq == 2'b10, "R2 passthrough follows dmaReq", int'(gatedReq), 2);

    // R3 edges ignored while disabled
    #1 dmaReq = 2'b00;
    pulse(0, 2);
    waitCycles(4);
    check(pendCount[CNTW-1:0] == 0, "R3 pend while disabled", int'(pendCount[CNTW-1:0]), 0);
    hsEnable[0] = 1'b1;
    monActive = 1'b1;
    dmaReq[0] = 1'b1;
    waitCycles(10);
    check(pendCount[CNTW-1:0] == 0, "R3 no pending after enable", int'(pendCount[CNTW-1:0]), 0);
    check(runLen == 0 && expQ.size() == 0, "R3 no grant for ignored edge", runLen, 0);

    // R5 single mode
    for (int i = 0; i < 4; i++) begin
      expectBurst(1, "R5 single transfer per edge");
      pulse(0, 2);
    end
    waitCycles(10);

    // R4 long held request counts once
    expectBurst(1, "R4 held level grants once");
    pulse(0, 30);
    waitCycles(10);

    // R6 block mode
    blockMode[0] = 1'b1;
    blockLen[LENW-1:0] = 8'd5;
    for (int i = 0; i < 3; i++) begin
      expectBurst(5, "R6 block of blockLen transfers");
      pulse(0, 2);
    end
    waitCycles(30);

    // R7 zero length acts as one
    blockLen[LENW-1:0] = 8'd0;
    expectBurst(1, "R7 zero block length grants one");
    pulse(0, 2);
    waitCycles(10);
    check(expQ.size() == 0, "R5/R6 all expected bursts seen", expQ.size(), 0);

    // R8 pending count with engine idle
    blockMode[0] = 1'b0;
    dmaReq[0] = 1'b0;
    for (int i = 0; i < 3; i++) pulse(0, 2);
    waitCycles(4);
    check(pendCount[CNTW-1:0] == 2, "R8 pending after three edges", int'(pendCount[CNTW-1:0]), 2);
    for (int i = 0; i < 3; i++) expectBurst(1, "R8 queued edges drain");
    dmaReq[0] = 1'b1;
    waitCycles(15);
    check(pendCount[CNTW-1:0] == 0, "R8 pending drained", int'(pendCount[CNTW-1:0]), 0);
    check(expQ.size() == 0, "R8 all queued grants seen", expQ.size(), 0);
    monActive = 1'b0;

    // R9 saturation and overflow, R11 independence
    dmaReq[0] = 1'b0;
    hsEnable[1] = 1'b1;
    dmaReq[1] = 1'b0;
    for (int i = 0; i < 7; i++) pulse(0, 2);
    waitCycles(4);
    check(pendCount[CNTW-1:0] == 6, "R8 pending below saturation", int'(pendCount[CNTW-1:0]), 6);
    check(overflow[0] == 1'b0, "R9 no overflow before saturation", int'(overflow[0]), 0);
    for (int i = 0; i < 3; i++) pulse(0, 2);
    waitCycles(4);
    check(pendCount[CNTW-1:0] == 7, "R9 pending saturates", int'(pendCount[CNTW-1:0]), 7);
    check(overflow[0] == 1'b1, "R9 overflow set", int'(overflow[0]), 1);
    check(pendCount[2*CNTW-1:CNTW] == 0, "R11 other channel pending", int'(pendCount[2*CNTW-1:CNTW]), 0);
    check(overflow[1] == 1'b0, "R11 other channel overflow", int'(overflow[1]), 0);
    waitCycles(5);
    check(overflow[0] == 1'b1, "R9 overflow sticky", int'(overflow[0]), 1);
    pulse(1, 2);
    pulse(1, 2);
    waitCycles(4);
    check(pendCount[2*CNTW-1:CNTW] == 1, "R11 channel 1 counts own edges", int'(pendCount[2*CNTW-1:CNTW]), 1);
    check(pendCount[CNTW-1:0] == 7, "R11 channel 0 unchanged", int'(pendCount[CNTW-1:0]), 7);
    hsEnable[0] = 1'b0;
    waitCycles(2);
    check(pendCount[CNTW-1:0] == 0, "R3 disable clears pending", int'(pendCount[CNTW-1:0]), 0);
    check(overflow[0] == 1'b0, "R3 disable clears overflow", int'(overflow[0]), 0);
    check(pendCount[2*CNTW-1:CNTW] == 1, "R11 channel 1 kept", int'(pendCount[2*CNTW-1:CNTW]), 1);
    @(negedge clk);
    check(gatedReq[1] == 1'b0, "R10 no grant without request", int'(gatedReq[1]), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule